// File: doc/BRIEF.md
# Long-Instruction Bundle Group Issuer

This block is the issue stage of a core that fetches wide instruction bundles made of six parcels and sends each parcel straight to a fixed lane. The lanes are bound to unit types: slot 0 feeds the branch unit, slots 1 to 3 feed the three integer lanes, and slots 4 and 5 feed the two floating-point lanes. No comparison logic runs between parcels. The compiler guarantees that parcels are independent. It also marks where each independent group ends by setting a stop bit on the last parcel of the group.

Without stop bits, a bundle issues all of its parcels in one cycle. With stop bits, the bundle is split into groups of adjacent slots, and each group issues in its own cycle, in slot order. This lets code built for a narrower machine run safely on this width. While groups of the current bundle remain, the issuer holds off new bundles.

Each parcel also carries a mask bit that silences it, for example on the partial last pass of a loop. Null parcels fill unused slots and never strobe a lane. A parcel whose class does not suit its slot is suppressed and raises an illegal-bundle flag.

Top module: `vliw_group_issue`

## Requirements
- R1: After reset, bundleReady is 1, laneIssue is all zero and illegalFlag is 0.
- R2: A bundle accepted at a clock edge (bundleValid and bundleReady both 1) with no stop bits strobes every legal, unmasked, non-null parcel on its lane in the cycle after that edge, all in that one cycle.
- R3: A parcel of class 2'b00 (null) never raises its lane's issue strobe.
- R4: A stop bit on slot j ends a group at j. Groups issue in successive cycles in ascending slot order, and no parcel after a stop issues in the same cycle as a parcel at or before it. A stop bit on slot 5 has no effect.
- R5: bundleReady is 0 while groups of the held bundle remain after the current one. It is 1 during the last group, so a waiting bundle is accepted at the end of that cycle and issues its first group in the next cycle.
- R6: A parcel whose mask bit is 1 does not strobe its lane. Its group still takes its cycle.
- R7: The class codes are 2'b11 branch, 2'b01 integer and 2'b10 float. Slot 0 accepts only branch, slots 1 to 3 only integer, and slots 4 and 5 only float. A non-null parcel of the wrong class is not issued, and illegalFlag is 1 in the cycle its group issues, whether or not the parcel is masked.
- R8: lanePayload slice i (bits 8*i+7 to 8*i) carries slot i's payload while laneIssue[i] is 1 and is zero otherwise. Parcel fields are packed by slot: class at bits 2*i+1 to 2*i, stop and mask at bit i.
- R9: When the last group has issued and no new bundle was accepted, laneIssue is all zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bundleValid | input | 1 | A bundle is offered |
| bundleReady | output | 1 | The issuer takes the offered bundle at this edge |
| bundleClass | input | 12 | Per-slot class codes, 2 bits per slot |
| bundleStop | input | 6 | Per-slot group-end bits |
| bundleMask | input | 6 | Per-slot disable bits |
| bundlePayload | input | 48 | Per-slot operation payload, 8 bits per slot |
| laneIssue | output | 6 | Per-lane issue strobes |
| lanePayload | output | 48 | Per-lane payload, zero on idle lanes |
| illegalFlag | output | 1 | The issuing group holds a parcel in the wrong slot |

## Verification
The assertions assume that bundle fields are stable and meaningful only at an edge where bundleValid and bundleReady are both high. They keep a shadow copy of the bundle taken at that edge and judge the lane strobes and payloads against it. The bench changes bundle inputs only at falling edges, and it offers a new bundle only while bundleReady is high or while it holds bundleValid and the fields steady until acceptance. As a result, the shadow copy always matches what the issuer holds.

// File: rtl/vliw_issue_pkg.sv
package vliw_issue_pkg;

  typedef enum logic [1:0] {
    CLS_NULL = 2'b00,
    CLS_INT  = 2'b01,
    CLS_FLT  = 2'b10,
    CLS_BR   = 2'b11
  } parcel_cls_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture the offered bundle
    logic advance;  // move to the next group
    logic active;   // a bundle is held
  } issue_ctl_t;

  // unit type bound to a slot: branch first, then integers, then floats
  function automatic parcel_cls_e slotClass(int slot, int intLanes);
    if (slot == 0) return CLS_BR;
    else if (slot <= intLanes) return CLS_INT;
    else return CLS_FLT;
  endfunction

endpackage

// File: rtl/vliw_issue_datapath.sv
module vliw_issue_datapath
  import vliw_issue_pkg::*;
#(
  parameter int INT_LANES = 3,
  parameter int FLT_LANES = 2,
  parameter int PAYLOAD_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  issue_ctl_t                  ctl,
  input  logic [2*(1+INT_LANES+FLT_LANES)-1:0]         inClass,
  input  logic [(1+INT_LANES+FLT_LANES)-1:0]           inStop,
  input  logic [(1+INT_LANES+FLT_LANES)-1:0]           inMask,
  input  logic [PAYLOAD_W*(1+INT_LANES+FLT_LANES)-1:0] inPayload,
  output logic                        lastGroup,
  output logic [(1+INT_LANES+FLT_LANES)-1:0]           laneIssue,
  output logic [PAYLOAD_W*(1+INT_LANES+FLT_LANES)-1:0] lanePayload,
  output logic                        illegalFlag
);
  localparam int SLOTS = 1 + INT_LANES + FLT_LANES;
  localparam int PTR_W = $clog2(SLOTS);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(SLOTS - 1);

  logic [2*SLOTS-1:0]         heldClass;
  logic [SLOTS-1:0]           heldStop;
  logic [SLOTS-1:0]           heldMask;
  logic [PAYLOAD_W*SLOTS-1:0] heldPayload;
  logic [PTR_W-1:0]           startPtr;
  logic [PTR_W-1:0]           groupEnd;
  logic [SLOTS-1:0]           misplaced;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldClass   <= '0;
      heldStop    <= '0;
      heldMask    <= '0;
      heldPayload <= '0;
      startPtr    <= '0;
    end else if (ctl.load) begin
      heldClass   <= inClass;
      heldStop    <= inStop;
      heldMask    <= inMask;
      heldPayload <= inPayload;
      startPtr    <= '0;
    end else if (ctl.advance) begin
      startPtr    <= groupEnd + PTR_W'(1);
    end
  end

  // first stop at or after the group start closes the group
  always_comb begin
    logic found;
    found    = 1'b0;
    groupEnd = LAST_SLOT;
    for (int j = 0; j < SLOTS; j++) begin
      if (!found && (PTR_W'(j) >= startPtr) && heldStop[j]) begin
        groupEnd = PTR_W'(j);
        found    = 1'b1;
      end
    end
  end

  assign lastGroup = (groupEnd == LAST_SLOT);

  for (genvar s = 0; s < SLOTS; s++) begin : g_lane
    localparam logic [PTR_W-1:0] SLOT_IDX = PTR_W'(s);
    localparam parcel_cls_e WANT = slotClass(s, INT_LANES);
    logic       inGroup;
    logic [1:0] cls;
    logic       nonNull;
    logic       fits;

    assign cls     = heldClass[2*s +: 2];
    assign inGroup = ctl.active && (SLOT_IDX >= startPtr) && (SLOT_IDX <= groupEnd);
    assign nonNull = (cls != CLS_NULL);
    assign fits    = (cls == WANT);

    assign laneIssue[s] = inGroup && nonNull && fits && !heldMask[s];
    assign misplaced[s] = inGroup && nonNull && !fits;
    assign lanePayload[PAYLOAD_W*s +: PAYLOAD_W] =
      laneIssue[s] ? heldPayload[PAYLOAD_W*s +: PAYLOAD_W] : '0;
  end

  assign illegalFlag = |misplaced;

endmodule

// File: rtl/vliw_issue_control.sv
module vliw_issue_control
  import vliw_issue_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bundleValid,
  input  logic       lastGroup,
  output logic       bundleReady,
  output issue_ctl_t ctl
);
  logic heldValid;

  assign bundleReady = !heldValid || lastGroup;
  assign ctl.load    = bundleValid && bundleReady;
  assign ctl.advance = heldValid && !lastGroup;
  assign ctl.active  = heldValid;

  always_ff @(posedge clk) begin
    if (!rstN)          heldValid <= 1'b0;
    else if (ctl.load)  heldValid <= 1'b1;
    else if (lastGroup) heldValid <= 1'b0;
  end

endmodule

// File: rtl/vliw_group_issue.sv
module vliw_group_issue
  import vliw_issue_pkg::*;
#(
  parameter int INT_LANES = 3,
  parameter int FLT_LANES = 2,
  parameter int PAYLOAD_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic bundleValid,
  output logic bundleReady,
  input  logic [2*(1+INT_LANES+FLT_LANES)-1:0]         bundleClass,
  input  logic [(1+INT_LANES+FLT_LANES)-1:0]           bundleStop,
  input  logic [(1+INT_LANES+FLT_LANES)-1:0]           bundleMask,
  input  logic [PAYLOAD_W*(1+INT_LANES+FLT_LANES)-1:0] bundlePayload,
  output logic [(1+INT_LANES+FLT_LANES)-1:0]           laneIssue,
  output logic [PAYLOAD_W*(1+INT_LANES+FLT_LANES)-1:0] lanePayload,
  output logic illegalFlag
);
  issue_ctl_t ctl;
  logic       lastGroup;

  vliw_issue_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .bundleValid (bundleValid),
    .lastGroup   (lastGroup),
    .bundleReady (bundleReady),
    .ctl         (ctl)
  );

  vliw_issue_datapath #(
    .INT_LANES (INT_LANES),
    .FLT_LANES (FLT_LANES),
    .PAYLOAD_W (PAYLOAD_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .inClass     (bundleClass),
    .inStop      (bundleStop),
    .inMask      (bundleMask),
    .inPayload   (bundlePayload),
    .lastGroup   (lastGroup),
    .laneIssue   (laneIssue),
    .lanePayload (lanePayload),
    .illegalFlag (illegalFlag)
  );

endmodule

// File: rtl/vliw_issue_checker.sv
module vliw_issue_checker
  import vliw_issue_pkg::*;
#(
  parameter int INT_LANES = 3,
  parameter int FLT_LANES = 2,
  parameter int PAYLOAD_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic bundleValid,
  input logic bundleReady,
  input logic [2*(1+INT_LANES+FLT_LANES)-1:0]         bundleClass,
  input logic [(1+INT_LANES+FLT_LANES)-1:0]           bundleMask,
  input logic [PAYLOAD_W*(1+INT_LANES+FLT_LANES)-1:0] bundlePayload,
  input logic [(1+INT_LANES+FLT_LANES)-1:0]           laneIssue,
  input logic [PAYLOAD_W*(1+INT_LANES+FLT_LANES)-1:0] lanePayload
);
  localparam int SLOTS = 1 + INT_LANES + FLT_LANES;

  logic [2*SLOTS-1:0]         shClass;
  logic [SLOTS-1:0]           shMask;
  logic [PAYLOAD_W*SLOTS-1:0] shPayload;
  logic [SLOTS-1:0]           shNull;
  logic [SLOTS-1:0]           shWrong;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shClass   <= '0;
      shMask    <= '0;
      shPayload <= '0;
    end else if (bundleValid && bundleReady) begin
      shClass   <= bundleClass;
      shMask    <= bundleMask;
      shPayload <= bundlePayload;
    end
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      shNull[s]  = (shClass[2*s +: 2] == CLS_NULL);
      shWrong[s] = (shClass[2*s +: 2] != slotClass(s, INT_LANES));
    end
  end

  assert_null_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (laneIssue & shNull) == '0);

  assert_masked_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (laneIssue & shMask) == '0);

  assert_slot_binding_R7: assert property (@(posedge clk) disable iff (!rstN)
    (laneIssue & shWrong) == '0);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bundleReady && !bundleValid) |=> (laneIssue == '0));

  for (genvar s = 0; s < SLOTS; s++) begin : g_pay
    assert_payload_R8: assert property (@(posedge clk) disable iff (!rstN)
      lanePayload[PAYLOAD_W*s +: PAYLOAD_W] ==
        (laneIssue[s] ? shPayload[PAYLOAD_W*s +: PAYLOAD_W] : '0));
  end

endmodule

bind vliw_group_issue vliw_issue_checker #(
  .INT_LANES (INT_LANES),
  .FLT_LANES (FLT_LANES),
  .PAYLOAD_W (PAYLOAD_W)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .bundleValid   (bundleValid),
  .bundleReady   (bundleReady),
  .bundleClass   (bundleClass),
  .bundleMask    (bundleMask),
  .bundlePayload (bundlePayload),
  .laneIssue     (laneIssue),
  .lanePayload   (lanePayload)
);

// File: tb/vliw_group_issue_test.sv
`timescale 1ns/1ps
module vliw_group_issue_test;
  localparam int SLOTS = 6;
  localparam int PW = 8;

  logic clk = 0;
  logic rstN = 0;
  logic bundleValid = 0;
  logic bundleReady;
  logic [2*SLOTS-1:0]  bundleClass = '0;
  logic [SLOTS-1:0]    bundleStop = '0;
  logic [SLOTS-1:0]    bundleMask = '0;
  logic [PW*SLOTS-1:0] bundlePayload = '0;
  logic [SLOTS-1:0]    laneIssue;
  logic [PW*SLOTS-1:0] lanePayload;
  logic illegalFlag;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  vliw_group_issue uut (
    .clk(clk), .rstN(rstN), .bundleValid(bundleValid), .bundleReady(bundleReady),
    .bundleClass(bundleClass), .bundleStop(bundleStop), .bundleMask(bundleMask),
    .bundlePayload(bundlePayload), .laneIssue(laneIssue),
    .lanePayload(lanePayload), .illegalFlag(illegalFlag)
  );

  // class codes: 00 null, 01 int, 10 float, 11 branch
  localparam logic [11:0] FULL = {2'b10, 2'b10, 2'b01, 2'b01, 2'b01, 2'b11};
  localparam logic [47:0] PAY  = 48'hF5_E4_D3_C2_B1_A0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] wantCls(int j);
    if (j == 0) return 2'b11;
    if (j <= 3) return 2'b01;
    return 2'b10;
  endfunction

  function automatic int grpEnd(logic [5:0] stop, int start);
    for (int j = start; j < SLOTS; j++) if (stop[j]) return j;
    return SLOTS - 1;
  endfunction

  task automatic expectGroup(input logic [11:0] cls, input logic [5:0] mask,
                             input logic [47:0] pay, input int start, input int e,
                             output logic [5:0] iss, output logic [47:0] py,
                             output logic ill);
    iss = '0; py = '0; ill = 0;
    for (int j = start; j <= e; j++) begin
      logic [1:0] c;
      c = cls[2*j +: 2];
      if (c != 2'b00 && c != wantCls(j)) ill = 1;
      if (c != 2'b00 && c == wantCls(j) && !mask[j]) begin
        iss[j] = 1;
        py[PW*j +: PW] = pay[PW*j +: PW];
      end
    end
  endtask

  // offer one bundle while idle, then check every group and the quiet cycle after
  task automatic runBundle(string tag, logic [11:0] cls, logic [5:0] stop,
                           logic [5:0] mask, logic [47:0] pay);
    int start;
    int e;
    logic [5:0] iss;
    logic [47:0] py;
    logic ill;
    @(negedge clk);
    bundleClass = cls; bundleStop = stop; bundleMask = mask; bundlePayload = pay;
    bundleValid = 1;
    @(posedge clk); #1 bundleValid = 0;
    start = 0;
    do begin
      e = grpEnd(stop, start);
      expectGroup(cls, mask, pay, start, e, iss, py, ill);
      @(negedge clk);
      check(laneIssue == iss, tag, "laneIssue", 64'(laneIssue), 64'(iss));
      check(lanePayload == py, "R8", "lanePayload", 64'(lanePayload), 64'(py));
      check(illegalFlag == ill, "R7", "illegalFlag", 64'(illegalFlag), 64'(ill));
      check(bundleReady == (e == SLOTS - 1), "R5", "bundleReady",
            64'(bundleReady), 64'(e == SLOTS - 1));
      start = e + 1;
    end while (e != SLOTS - 1);
    @(negedge clk);
    check(laneIssue == '0, "R9", "laneIssue idle", 64'(laneIssue), 64'(0));
    check(bundleReady == 1'b1, "R9", "bundleReady idle", 64'(bundleReady), 64'(1));
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(bundleReady == 1'b1, "R1", "bundleReady", 64'(bundleReady), 64'(1));
    check(laneIssue == '0, "R1", "laneIssue", 64'(laneIssue), 64'(0));
    check(illegalFlag == 1'b0, "R1", "illegalFlag", 64'(illegalFlag), 64'(0));
  endtask

  task automatic test_full();
    runBundle("R2", FULL, 6'b000000, 6'b000000, PAY);
  endtask

  task automatic test_nulls();
    // slots 1 and 4 null, slot 0 null too
    runBundle("R3", {2'b10, 2'b00, 2'b01, 2'b01, 2'b00, 2'b00}, 6'b000000, 6'b000000, PAY);
  endtask

  task automatic test_stops();
    // groups: [0], [1..3], [4..5]
    runBundle("R4", FULL, 6'b001001, 6'b000000, PAY);
    // every slot its own group
    runBundle("R4", FULL, 6'b111111, 6'b000000, 48'h0102_0304_0506);
    // stop on last slot only: one group
    runBundle("R4", FULL, 6'b100000, 6'b000000, PAY);
  endtask

  task automatic test_mask();
    runBundle("R6", FULL, 6'b000000, 6'b010110, PAY);
    runBundle("R6", FULL, 6'b000010, 6'b111111, PAY);
  endtask

  task automatic test_illegal();
    // slot 2 float, slot 5 branch: misplaced
    runBundle("R7", {2'b11, 2'b10, 2'b01, 2'b10, 2'b01, 2'b11}, 6'b000100, 6'b000000, PAY);
    // misplaced but masked still flags
    runBundle("R7", {2'b10, 2'b10, 2'b01, 2'b01, 2'b01, 2'b01}, 6'b000000, 6'b000001, PAY);
  endtask

  task automatic test_back_to_back();
    logic [5:0] issA1;
    logic [5:0] issB;
    logic [47:0] py;
    logic ill;
    @(negedge clk);
    bundleClass = FULL; bundleStop = 6'b000100; bundleMask = '0; bundlePayload = PAY;
    bundleValid = 1;
    @(posedge clk); #1;
    bundleClass = {2'b10, 2'b00, 2'b01, 2'b00, 2'b01, 2'b11};
    bundleStop = '0; bundlePayload = 48'h1112_1314_1516;
    @(negedge clk);
    check(bundleReady == 1'b0, "R5", "ready during first group", 64'(bundleReady), 64'(0));
    check(laneIssue == 6'b000111, "R4", "first group", 64'(laneIssue), 64'(6'b000111));
    @(negedge clk);
    expectGroup(FULL, 6'b0, PAY, 3, 5, issA1, py, ill);
    check(bundleReady == 1'b1, "R5", "ready during last group", 64'(bundleReady), 64'(1));
    check(laneIssue == issA1, "R4", "second group", 64'(laneIssue), 64'(issA1));
    @(posedge clk); #1 bundleValid = 0;
    @(negedge clk);
    expectGroup({2'b10, 2'b00, 2'b01, 2'b00, 2'b01, 2'b11}, 6'b0, 48'h1112_1314_1516,
                0, 5, issB, py, ill);
    check(laneIssue == issB, "R5", "next bundle at once", 64'(laneIssue), 64'(issB));
    check(lanePayload == py, "R8", "next bundle payload", 64'(lanePayload), 64'(py));
    @(negedge clk);
    check(laneIssue == '0, "R9", "quiet after", 64'(laneIssue), 64'(0));
  endtask

  initial begin
    #100000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    test_reset();
    test_full();
    test_nulls();
    test_stops();
    test_mask();
    test_illegal();
    test_back_to_back();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule